// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a synchronous request bus to an external asynchronous static RAM of 128K words by 16 bits. It accepts one word at a time through a valid/ready handshake. Each request carries an address, write data, a two-bit byte mask and a direction flag. The controller then produces the pin sequence that the RAM expects. Those pins are the address, the active-low chip select, the output enable, the write strobe and the two byte-lane enables. The bidirectional data bus is split into an input, an output and a drive-enable.

Each RAM timing minimum is a parameter in nanoseconds, as is the clock period. The phase lengths are the ceilings of those values divided by the clock period, and each phase lasts at least one cycle:
- The read phase uses the longest of cycle time, address access and output-enable access.
- The write pulse uses the longest of pulse width, address-to-end and data-to-end. It is also stretched so that the pulse plus one hold cycle covers the write cycle time.
- The turnaround count comes from the bus release time.

When the direction of the bus changes between two accesses, the controller inserts a quiet gap of that many cycles. During the gap no driver is enabled and output enable stays high. Two accesses in the same direction start with no gap.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and directly after reset, ce_n, oe_n, we_n, ub_n and lb_n are all high, dq_oe is 0, rsp_valid is 0 and req_ready is 1.
- R2: A read holds ce_n and oe_n low for exactly RD_CYC cycles (3 at the default 20 ns clock) with the address stable. Data sampled at the edge that closes this window is returned on rsp_rdata. rsp_valid is high for exactly one cycle, in the cycle after that edge.
- R3: A write drives we_n low for exactly PW_CYC cycles (2 by default). During that time ce_n is low, dq_oe is 1 and the address and data are stable. we_n rises first, while address, data, lanes, ce_n and dq_oe stay unchanged for one more cycle. Then ce_n rises and dq_oe drops.
- R4: Mask bit 1 drives ub_n low and mask bit 0 drives lb_n low for the whole access. While ce_n is high in two consecutive cycles, ub_n and lb_n do not change.
- R5: we_n and oe_n are never low together, and dq_oe is never 1 while oe_n is low.
- R6: When a read follows a write, or a write follows a read, the access is delayed by TURN_CYC cycles (1 by default). During those cycles ce_n and oe_n are high and dq_oe is 0. The gap between the last drive by one side and the first drive by the other is at least TURN_CYC cycles.
- R7: req_ready is high only while the controller is idle. In that state ce_n, oe_n and we_n are high. After a read is accepted, req_ready returns after RD_CYC+1 cycles plus any turnaround. After a write is accepted, it returns after PW_CYC+2 cycles plus any turnaround.
- R8: An access in the same direction as the previous one, or the first access after reset, drives its pins in the cycle right after the accepting edge.
- R9: rsp_valid is raised only for reads, never for writes.
- R10: A write changes only the bytes whose mask bit is 1. A mask of 00 runs the full write sequence and leaves the stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask, bit 1 upper, bit 0 lower |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, valid on enabled lanes |
| ram_addr | output | 17 | RAM address |
| ram_ce_n | output | 1 | RAM chip select, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_ub_n | output | 1 | Upper byte lane enable, active low |
| ram_lb_n | output | 1 | Lower byte lane enable, active low |
| ram_dq_i | input | 16 | Data from RAM pins |
| ram_dq_o | output | 16 | Data to RAM pins |
| ram_dq_oe | output | 1 | Drive enable for ram_dq_o |

## Verification
A wrong phase counter shows up first as a strobe of the wrong length: an oe_n or we_n pulse one cycle too long or too short. It is visible at the pins within the same access, and it also shifts the cycle in which req_ready and rsp_valid return. A stale direction flag either drops the turnaround gap or inserts one that is not needed. Either way the pins of the next access move by exactly TURN_CYC cycles. A lane or hold error corrupts bytes in the RAM model, and the fault appears on the read-back of that address later in the sweep.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int AW        = 17,
  parameter int DW        = 16,
  parameter int CLK_NS    = 20,
  parameter int T_RC_NS   = 55,
  parameter int T_AA_NS   = 55,
  parameter int T_DOE_NS  = 25,
  parameter int T_WC_NS   = 45,
  parameter int T_PWE_NS  = 35,
  parameter int T_AW_NS   = 35,
  parameter int T_SD_NS   = 25,
  parameter int T_TURN_NS = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] ram_addr,
  output logic          ram_ce_n,
  output logic          ram_oe_n,
  output logic          ram_we_n,
  output logic          ram_ub_n,
  output logic          ram_lb_n,
  input  logic [DW-1:0] ram_dq_i,
  output logic [DW-1:0] ram_dq_o,
  output logic          ram_dq_oe
);

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int cyc(int ns);
    return mx((ns + CLK_NS - 1) / CLK_NS, 1);
  endfunction

  localparam int RD_CYC   = cyc(mx(mx(T_RC_NS, T_AA_NS), T_DOE_NS));
  localparam int PW_CYC   = mx(cyc(mx(mx(T_PWE_NS, T_AW_NS), T_SD_NS)), cyc(T_WC_NS) - 1);
  localparam int TURN_CYC = cyc(T_TURN_NS);
  localparam int CW       = $clog2(mx(mx(RD_CYC, PW_CYC), TURN_CYC) + 1);

  typedef enum logic [2:0] {S_IDLE, S_TURN, S_RD, S_WP, S_WH} state_t;

  state_t          state;
  logic [CW-1:0]   cnt;
  logic            have_prev, prev_wr;
  logic            op_wr;
  logic [AW-1:0]   op_addr;
  logic [DW-1:0]   op_data;
  logic [1:0]      op_be;

  logic need_turn, from_turn, go, go_wr;
  logic [AW-1:0] go_addr;
  logic [DW-1:0] go_data;
  logic [1:0]    go_be;

  assign req_ready = (state == S_IDLE);
  assign need_turn = have_prev && (prev_wr != req_write);
  assign from_turn = (state == S_TURN) && (cnt == '0);
  assign go        = (req_ready && req_valid && !need_turn) || from_turn;
  assign go_wr     = from_turn ? op_wr   : req_write;
  assign go_addr   = from_turn ? op_addr : req_addr;
  assign go_data   = from_turn ? op_data : req_wdata;
  assign go_be     = from_turn ? op_be   : req_be;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      have_prev <= 1'b0;
      prev_wr   <= 1'b0;
      op_wr     <= 1'b0;
      op_addr   <= '0;
      op_data   <= '0;
      op_be     <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      ram_addr  <= '0;
      ram_ce_n  <= 1'b1;
      ram_oe_n  <= 1'b1;
      ram_we_n  <= 1'b1;
      ram_ub_n  <= 1'b1;
      ram_lb_n  <= 1'b1;
      ram_dq_o  <= '0;
      ram_dq_oe <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid && need_turn) begin
          state   <= S_TURN;
          cnt     <= CW'(TURN_CYC - 1);
          op_wr   <= req_write;
          op_addr <= req_addr;
          op_data <= req_wdata;
          op_be   <= req_be;
        end
        S_TURN: if (cnt != '0) cnt <= cnt - 1'b1;
        S_RD: if (cnt == '0) begin
          rsp_rdata <= ram_dq_i;
          rsp_valid <= 1'b1;
          ram_ce_n  <= 1'b1;
          ram_oe_n  <= 1'b1;
          state     <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        S_WP: if (cnt == '0) begin
          ram_we_n <= 1'b1;
          state    <= S_WH;
        end else cnt <= cnt - 1'b1;
        S_WH: begin
          ram_ce_n  <= 1'b1;
          ram_dq_oe <= 1'b0;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
      if (go) begin
        state     <= go_wr ? S_WP : S_RD;
        cnt       <= go_wr ? CW'(PW_CYC - 1) : CW'(RD_CYC - 1);
        have_prev <= 1'b1;
        prev_wr   <= go_wr;
        ram_addr  <= go_addr;
        ram_ce_n  <= 1'b0;
        ram_ub_n  <= ~go_be[1];
        ram_lb_n  <= ~go_be[0];
        ram_we_n  <= ~go_wr;
        ram_oe_n  <= go_wr;
        ram_dq_o  <= go_data;
        ram_dq_oe <= go_wr;
      end
    end
  end

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int AW = 17,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] ram_addr,
  input logic          ram_ce_n,
  input logic          ram_oe_n,
  input logic          ram_we_n,
  input logic          ram_ub_n,
  input logic          ram_lb_n,
  input logic [DW-1:0] ram_dq_o,
  input logic          ram_dq_oe
);

  assert_strobe_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ram_we_n && !ram_oe_n));

  assert_no_drive_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_dq_oe && !ram_oe_n));

  assert_lane_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_ce_n && $past(ram_ce_n)) |-> $stable({ram_ub_n, ram_lb_n}));

  assert_we_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> (!ram_ce_n && ram_dq_oe));

  assert_we_end_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> (!ram_ce_n && ram_dq_oe && $stable(ram_dq_o) && $stable(ram_addr)
                         && $stable({ram_ub_n, ram_lb_n})));

  assert_write_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_we_n && $past(!ram_we_n)) |-> ($stable(ram_dq_o) && $stable(ram_addr)));

  assert_rsp_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_rsp_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(!ram_oe_n) && ram_oe_n));

  assert_ready_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ram_ce_n && ram_oe_n && ram_we_n));

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.AW(AW), .DW(DW)) chk_i (.*);

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;
  localparam int TCLK     = 20;
  localparam int RD_EXP   = (55 + TCLK - 1) / TCLK;
  localparam int PWA      = (35 + TCLK - 1) / TCLK;
  localparam int PWB      = (45 + TCLK - 1) / TCLK - 1;
  localparam int PW_EXP   = (PWA > PWB) ? PWA : PWB;
  localparam int TURN_EXP = (18 + TCLK - 1) / TCLK;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0, req_ready, rsp_valid;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0, rsp_rdata, ram_dq_i, ram_dq_o;
  logic [1:0]  req_be = '0;
  logic [16:0] ram_addr;
  logic        ram_ce_n, ram_oe_n, ram_we_n, ram_ub_n, ram_lb_n, ram_dq_oe;

  sram_async_ctrl #(.CLK_NS(TCLK)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ram_addr(ram_addr),
    .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
    .ram_ub_n(ram_ub_n), .ram_lb_n(ram_lb_n), .ram_dq_i(ram_dq_i),
    .ram_dq_o(ram_dq_o), .ram_dq_oe(ram_dq_oe));

  logic [15:0] ram [256];
  logic [15:0] exp_mem [256];
  int n_cmp = 0, n_bad = 0;
  bit mon_on = 1'b0, have_prev = 1'b0, last_w = 1'b0;

  always @(posedge ram_we_n) if (ram_ce_n === 1'b0) begin
    if (!ram_ub_n) ram[ram_addr[7:0]][15:8] <= ram_dq_o[15:8];
    if (!ram_lb_n) ram[ram_addr[7:0]][7:0]  <= ram_dq_o[7:0];
  end
  assign ram_dq_i = (!ram_ce_n && !ram_oe_n) ?
    {ram_ub_n ? 8'h00 : ram[ram_addr[7:0]][15:8], ram_lb_n ? 8'h00 : ram[ram_addr[7:0]][7:0]} : 16'h0000;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, expv, $time);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  int we_run = 0, oe_run = 0, q_run = 0, last_drv = 0;
  logic prev_ce = 1'b1, prev_oe = 1'b1, prev_dqoe = 1'b0;
  logic [1:0] prev_ln = 2'b11;
  always @(negedge clk) if (mon_on) begin
    if (!ram_we_n) we_run++;
    else if (we_run > 0) begin
      chk(we_run == PW_EXP, "R3 pulse width", we_run, PW_EXP);
      chk(!ram_ce_n && ram_dq_oe, "R3 hold after we_n rise", {ram_ce_n, ram_dq_oe}, 2'b01);
      we_run = 0;
    end
    if (!ram_oe_n) oe_run++;
    else if (oe_run > 0) begin
      chk(oe_run == RD_EXP, "R2 read window", oe_run, RD_EXP);
      oe_run = 0;
    end
    if (!ram_oe_n) chk(ram_we_n && !ram_dq_oe, "R5 exclusive", {ram_we_n, ram_dq_oe}, 2'b10);
    if (ram_ce_n && prev_ce) chk({ram_ub_n, ram_lb_n} == prev_ln, "R4 lanes quiet", {ram_ub_n, ram_lb_n}, prev_ln);
    if (!ram_oe_n && prev_oe && last_drv == 2) chk(q_run >= TURN_EXP, "R6 write->read gap", q_run, TURN_EXP);
    if (ram_dq_oe && !prev_dqoe && last_drv == 1) chk(q_run >= TURN_EXP, "R6 read->write gap", q_run, TURN_EXP);
    if (!ram_oe_n) last_drv = 1;
    if (ram_dq_oe) last_drv = 2;
    q_run = (ram_oe_n && !ram_dq_oe) ? q_run + 1 : 0;
    prev_ce = ram_ce_n; prev_oe = ram_oe_n; prev_dqoe = ram_dq_oe;
    prev_ln = {ram_ub_n, ram_lb_n};
  end

  task automatic access(input bit w, input logic [16:0] a, input logic [15:0] d, input logic [1:0] be);
    bit turn = have_prev && (last_w != w);
    int skip = turn ? TURN_EXP : 0;
    int lat  = w ? PW_EXP + 2 + skip : RD_EXP + 1 + skip;
    bit busy_ok = 1'b1, rsp_ok = 1'b1;
    logic [15:0] mask = {{8{be[1]}}, {8{be[0]}}};
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k <= lat; k++) begin
      if (k > 1) @(negedge clk);
      if (turn && k == 1)
        chk(ram_ce_n && ram_oe_n && !ram_dq_oe, "R6 quiet turnaround", {ram_ce_n, ram_oe_n, ram_dq_oe}, 3'b110);
      if (k == 1 + skip) begin
        if (!turn) chk(!ram_ce_n, "R8 start on accept", ram_ce_n, 1'b0);
        chk(ram_addr == a, "R2/R3 address", ram_addr, a);
        chk({ram_ub_n, ram_lb_n} == ~be, "R4 lane enables", {ram_ub_n, ram_lb_n}, ~be);
        chk({ram_ce_n, ram_we_n, ram_oe_n, ram_dq_oe} == {1'b0, ~w, w, w}, "R2/R3 strobes",
            {ram_ce_n, ram_we_n, ram_oe_n, ram_dq_oe}, {1'b0, ~w, w, w});
        if (w) chk(ram_dq_o == d, "R3 write data", ram_dq_o, d);
      end
      if (k < lat) begin
        if (req_ready) busy_ok = 1'b0;
        if (rsp_valid) rsp_ok = 1'b0;
      end else begin
        chk(req_ready, "R7 ready return", req_ready, 1'b1);
        if (w) chk(!rsp_valid, "R9 no response on write", rsp_valid, 1'b0);
        else begin
          chk(rsp_valid, "R2 response strobe", rsp_valid, 1'b1);
          chk((rsp_rdata & mask) == (exp_mem[a[7:0]] & mask), "R2/R10 read data",
              rsp_rdata & mask, exp_mem[a[7:0]] & mask);
        end
      end
    end
    chk(busy_ok, "R7 ready low while busy", busy_ok, 1'b1);
    chk(rsp_ok, "R2/R9 no early response", rsp_ok, 1'b1);
    if (w) begin
      if (be[1]) exp_mem[a[7:0]][15:8] = d[15:8];
      if (be[0]) exp_mem[a[7:0]][7:0]  = d[7:0];
    end
    have_prev = 1'b1; last_w = w;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R7 watchdog", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin ram[i] = 16'h0000; exp_mem[i] = 16'h0000; end
    repeat (3) @(negedge clk);
    chk({ram_ce_n, ram_oe_n, ram_we_n, ram_ub_n, ram_lb_n, ram_dq_oe, rsp_valid, req_ready} == 8'b11111001,
        "R1 reset state", {ram_ce_n, ram_oe_n, ram_we_n, ram_ub_n, ram_lb_n, ram_dq_oe, rsp_valid, req_ready}, 8'b11111001);
    rst_n = 1'b1;
    @(negedge clk);
    chk({ram_ce_n, ram_oe_n, ram_we_n, ram_dq_oe, req_ready} == 5'b11101, "R1 after release",
        {ram_ce_n, ram_oe_n, ram_we_n, ram_dq_oe, req_ready}, 5'b11101);
    mon_on = 1'b1;
    for (int a = 0; a < 64; a++) access(1'b1, 17'(a), 16'(a * 16'h0111) ^ 16'h5A3C, 2'b11);
    for (int a = 0; a < 64; a++) access(1'b1, 17'(a) | 17'h1FF00, 16'(a * 16'h2305) ^ 16'hC3E1, 2'(a % 4));
    for (int a = 0; a < 64; a++) access(1'b0, 17'(a), 16'h0000, 2'b11);
    for (int a = 0; a < 32; a++) begin
      access(1'b1, 17'(a + 64), 16'(a * 16'h0F1D) + 16'h1234, 2'((a % 3) + 1));
      access(1'b0, 17'(a + 64), 16'h0000, 2'((a % 3) + 1));
    end
    for (int a = 0; a < 32; a++) access(1'b0, 17'(a * 2), 16'h0000, 2'(a % 3 + 1));
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule